// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six switches of a three-phase bridge. Each phase has two outputs: a positive one and a negative one. The two outputs of a phase are never on together, and a dead interval is inserted between them at every switch.

The block has no delay stage on each edge. Instead it runs two triangular counters on one shared enable. The lead counter starts at a programmed offset and the trailing counter starts at zero. A phase compares its threshold against both counters. The positive output is on only while both counters are below the threshold, and the negative output is on only while both are at or above it. Whenever the two counters disagree, both outputs of that phase stay low. That gap is the dead time, and it is exactly as long as the offset.

Software writes six registers through a plain write port. It then enters the mode with the counters stopped and raises the run control. A six-bit mask gates each pin individually.

Top module: `cpwm3_gen`

## Requirements
- R1: After reset, all six outputs are low, all registers are zero and the mode is inactive.
- R2: While active and running, each counter changes by one per cycle. It counts up to the cycle value, then down to zero, and turns around at each end without dwelling there. For example, 0,1,..,C,C-1,..,0,1.
- R3: On each counting edge, `pwm_o[k]` (k=0,1,2 for phases u,v,w) registers high exactly when both counter values held before that edge are below compare k. A compare value at or above the cycle value forces it high.
- R4: On each counting edge, `pwm_o[3+k]` registers high exactly when both counter values are at or above compare k and compare k is below the cycle value.
- R5: `pwm_o[k]` and `pwm_o[3+k]` are never high together.
- R6: A compare value of zero holds the positive output low and the negative output high. A compare value equal to the cycle value holds the positive output high and the negative output low. Neither case shows any glitch.
- R7: Mask bit i gates `pwm_o[i]`. A cleared bit holds that pin low.
- R8: With `run_i` low, both counters and all outputs hold their values.
- R9: The mode is entered only on a cycle where `mode_en_i` is high, it was low on the previous cycle, and `run_i` is low. On entry, the lead counter loads the offset, the trailing counter loads zero, both count up, and the outputs are cleared. A rise with `run_i` high is ignored until `mode_en_i` falls and rises again.
- R10: With `mode_en_i` low, all outputs are low from the next clock edge.
- R11: A write stores `wr_data_i` at a clock edge. The addresses are: 0 cycle, 1 compare u, 2 compare v, 3 compare w, 4 offset (lead counter preload), 5 output mask in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CW | Register write data |
| run_i | input | 1 | Shared count enable for both counters |
| mode_en_i | input | 1 | Complementary mode request |
| pwm_o | output | 6 | Bits 2:0 are the positive outputs u,v,w; bits 5:3 are the negative outputs |

## Verification
The bench sweeps three cycle values and two offsets. For each pair it moves the compare value of every phase through the whole range from zero to the cycle value, giving the three phases different values at the same time. A mismatch therefore shows a wrong phase index or a swapped pin. It also separates an off-by-one at the turnaround or the threshold, and a dead gap that is not tied to the offset. Further sequences pause the count mid-carrier, change the mask while running, drop the mode, and raise the mode while running. These show that holding, gating, shutdown and the entry condition each act on their own.

// File: rtl/cpwm3_pkg.sv
package cpwm3_pkg;
  localparam int NPH  = 3;
  localparam int NOUT = 2 * NPH;
  localparam int AW   = 3;

  typedef enum logic [AW-1:0] {
    A_CYC   = 3'd0,
    A_CMP_U = 3'd1,
    A_CMP_V = 3'd2,
    A_CMP_W = 3'd3,
    A_OFS   = 3'd4,
    A_MASK  = 3'd5
  } reg_addr_e;

  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/cpwm3_regs.sv
module cpwm3_regs
  import cpwm3_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [CW-1:0]            wr_data_i,
  output logic [CW-1:0]            cyc_o,
  output logic [NPH-1:0][CW-1:0]   cmp_o,
  output logic [CW-1:0]            ofs_o,
  output logic [NOUT-1:0]          mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o  <= '0;
      cmp_o  <= '0;
      ofs_o  <= '0;
      mask_o <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_CYC:   cyc_o    <= wr_data_i;
        A_CMP_U: cmp_o[0] <= wr_data_i;
        A_CMP_V: cmp_o[1] <= wr_data_i;
        A_CMP_W: cmp_o[2] <= wr_data_i;
        A_OFS:   ofs_o    <= wr_data_i;
        A_MASK:  mask_o   <= wr_data_i[NOUT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpwm3_tri_cnt.sv
module cpwm3_tri_cnt
  import cpwm3_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          en_i,
  input  logic [CW-1:0] cyc_i,
  output logic [CW-1:0] cnt_o
);
  dir_e dir_q;
  logic cyc_zero;

  assign cyc_zero = (cyc_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dir_q <= DIR_UP;
    end else if (ld_i) begin
      cnt_o <= ld_val_i;
      dir_q <= DIR_UP;
    end else if (en_i) begin
      if (dir_q == DIR_UP) begin
        if (cnt_o >= cyc_i) begin
          // turn at the top without dwelling
          cnt_o <= cyc_zero ? '0 : cyc_i - 1'b1;
          dir_q <= cyc_zero ? DIR_UP : DIR_DN;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end else begin
        if (cnt_o == '0) begin
          cnt_o <= cyc_zero ? '0 : CW'(1);
          dir_q <= DIR_UP;
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpwm3_phase.sv
module cpwm3_phase #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] cnt_a_i,
  input  logic [CW-1:0] cnt_b_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [CW-1:0] cyc_i,
  output logic          pos_o,
  output logic          neg_o
);
  logic full, a_lo, b_lo;

  assign full  = (cmp_i >= cyc_i);
  assign a_lo  = full | (cnt_a_i < cmp_i);
  assign b_lo  = full | (cnt_b_i < cmp_i);
  // both counters must agree; disagreement is the dead gap
  assign pos_o = a_lo & b_lo;
  assign neg_o = ~a_lo & ~b_lo;
endmodule

// File: rtl/cpwm3_gen.sv
module cpwm3_gen
  import cpwm3_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_addr_i,
  input  logic [CW-1:0]   wr_data_i,
  input  logic            run_i,
  input  logic            mode_en_i,
  output logic [5:0]      pwm_o
);
  logic [CW-1:0]           cyc_w, ofs_w, cnt_a, cnt_b;
  logic [NPH-1:0][CW-1:0]  cmp_w;
  logic [NOUT-1:0]         mask_w, out_q, nxt_out;
  logic [NPH-1:0]          pos_w, neg_w;
  logic                    mode_q, act_q, entry, tick;

  cpwm3_regs #(.CW(CW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cyc_o(cyc_w), .cmp_o(cmp_w), .ofs_o(ofs_w),
    .mask_o(mask_w)
  );

  assign entry = mode_en_i & ~mode_q & ~run_i;
  assign tick  = act_q & run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      mode_q <= mode_en_i;
      if (!mode_en_i)  act_q <= 1'b0;
      else if (entry)  act_q <= 1'b1;
    end
  end

  cpwm3_tri_cnt #(.CW(CW)) u_cnt_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(entry), .ld_val_i(ofs_w),
    .en_i(tick), .cyc_i(cyc_w), .cnt_o(cnt_a)
  );

  cpwm3_tri_cnt #(.CW(CW)) u_cnt_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(entry), .ld_val_i('0),
    .en_i(tick), .cyc_i(cyc_w), .cnt_o(cnt_b)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    cpwm3_phase #(.CW(CW)) u_ph (
      .cnt_a_i(cnt_a), .cnt_b_i(cnt_b), .cmp_i(cmp_w[k]), .cyc_i(cyc_w),
      .pos_o(pos_w[k]), .neg_o(neg_w[k])
    );
  end

  assign nxt_out = {neg_w, pos_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   out_q <= '0;
    else if (!mode_en_i || entry)  out_q <= '0;
    else if (tick)                 out_q <= nxt_out;
  end

  assign pwm_o = out_q & mask_w;
endmodule

// File: rtl/cpwm3_chk.sv
module cpwm3_chk #(
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          run_i,
  input logic          mode_en_i,
  input logic [5:0]    pwm_o,
  input logic          mode_q,
  input logic          act_q,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] cyc_w,
  input logic [5:0]    mask_w
);
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o[2:0] & pwm_o[5:3]) == 3'b000);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && run_i && cyc_w != '0 && cnt_a <= cyc_w) |=>
      (cnt_a == CW'($past(cnt_a) + 1'b1)) || (cnt_a == CW'($past(cnt_a) - 1'b1)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !run_i && mode_en_i && !wr_en_i) |=>
      $stable(pwm_o) && $stable(cnt_a) && $stable(cnt_b));

  p_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> pwm_o == 6'b0);

  p_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && !mode_q && !run_i) |=> (cnt_b == '0 && pwm_o == 6'b0 && act_q));

  p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~mask_w) == 6'b0);
endmodule

bind cpwm3_gen cpwm3_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .run_i(run_i),
  .mode_en_i(mode_en_i), .pwm_o(pwm_o), .mode_q(mode_q), .act_q(act_q),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .cyc_w(cyc_w), .mask_w(mask_w)
);

// File: tb/sim_cpwm3_gen.sv
module sim_cpwm3_gen;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          run = 1'b0;
  logic          mode_en = 1'b0;
  logic [5:0]    pwm;

  always #4 clk = ~clk;

  cpwm3_gen #(.CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .run_i(run), .mode_en_i(mode_en), .pwm_o(pwm)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_cyc = 0, m_ofs = 0, m_a = 0, m_b = 0;
  int m_cmp [3] = '{0, 0, 0};
  bit m_ad = 0, m_bd = 0, m_act = 0, m_mq = 0;
  logic [5:0] m_out = '0, m_mask = '0;

  function automatic bit below(int cnt, int c, int cy);
    return (c >= cy) ? 1'b1 : (cnt < c);
  endfunction

  // R2: triangular step
  task automatic stp(inout int cnt, inout bit dn, input int cy);
    if (!dn) begin
      if (cnt >= cy) begin cnt = (cy == 0) ? 0 : cy - 1; dn = (cy != 0); end
      else cnt = cnt + 1;
    end else begin
      if (cnt == 0) begin cnt = (cy == 0) ? 0 : 1; dn = 0; end
      else cnt = cnt - 1;
    end
  endtask

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    logic [5:0] nxt;
    bit ent, go, pa, pb;
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      pa = below(m_a, m_cmp[k], m_cyc);
      pb = below(m_b, m_cmp[k], m_cyc);
      nxt[k]   = pa & pb;
      nxt[k+3] = !pa & !pb;
    end
    ent = mode_en && !m_mq && !run;
    go  = m_act && run;
    if (!mode_en || ent) m_out = '0;
    else if (go) m_out = nxt;
    if (ent) begin m_a = m_ofs; m_ad = 0; m_b = 0; m_bd = 0; end
    else if (go) begin stp(m_a, m_ad, m_cyc); stp(m_b, m_bd, m_cyc); end
    if (!mode_en) m_act = 0;
    else if (ent) m_act = 1;
    m_mq = mode_en;
    if (wr_en) begin // R11 map
      case (wr_addr)
        3'd0: m_cyc = int'(wr_data);
        3'd1: m_cmp[0] = int'(wr_data);
        3'd2: m_cmp[1] = int'(wr_data);
        3'd3: m_cmp[2] = int'(wr_data);
        3'd4: m_ofs = int'(wr_data);
        3'd5: m_mask = wr_data[5:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk(tag, pwm, m_out & m_mask);
    chk("R5", pwm[2:0] & pwm[5:3], 3'b000);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = CW'(d);
    tick("R11");
    wr_en = 1'b0;
  endtask

  task automatic setup(input int cy, input int of, input int u, input int v, input int w, input int mk);
    mode_en = 1'b0; run = 1'b0;
    tick("R10");
    wr(0, cy); wr(1, u); wr(2, v); wr(3, w); wr(4, of); wr(5, mk);
    mode_en = 1'b1;
    tick("R9");
    run = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] snap;
    int cys [3] = '{3, 5, 8};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pwm, 6'b0);

    // R2 R3 R4 R6: sweep of carrier, offset and all compare values
    foreach (cys[i]) begin
      for (int of = 1; of <= 2; of++) begin
        for (int c = 0; c <= cys[i]; c++) begin
          setup(cys[i], of, c, (c + 1) % (cys[i] + 1), cys[i] - c, 6'h3f);
          repeat (4 * cys[i] + 2) tick("R3 R4");
        end
      end
    end

    // R6: steady extremes
    setup(6, 2, 0, 6, 3, 6'h3f);
    tick("R6");
    repeat (24) begin
      tick("R6");
      chk("R6", {pwm[4], pwm[1], pwm[3], pwm[0]}, 4'b0110);
    end

    // R8: pause mid-carrier
    snap = pwm;
    run = 1'b0;
    tick("R8");
    snap = pwm;
    repeat (5) begin
      tick("R8");
      chk("R8", pwm, snap);
    end
    run = 1'b1;
    repeat (10) tick("R8");

    // R7: mask gating while running
    wr(5, 6'b101010);
    repeat (12) begin
      tick("R7");
      chk("R7", pwm & 6'b010101, 6'b0);
    end
    wr(5, 0);
    repeat (4) begin
      tick("R7");
      chk("R7", pwm, 6'b0);
    end
    wr(5, 6'h3f);
    repeat (4) tick("R7");

    // R10: drop the mode while running
    mode_en = 1'b0;
    tick("R10");
    chk("R10", pwm, 6'b0);

    // R9: rise with run high is ignored
    setup(5, 1, 2, 3, 4, 6'h3f);
    mode_en = 1'b0; tick("R9");
    mode_en = 1'b1; tick("R9");
    repeat (8) begin tick("R9"); chk("R9", pwm, 6'b0); end
    run = 1'b0;
    repeat (3) begin tick("R9"); chk("R9", pwm, 6'b0); end
    run = 1'b1;
    repeat (4) begin tick("R9"); chk("R9", pwm, 6'b0); end
    run = 1'b0; mode_en = 1'b0; tick("R9");
    mode_en = 1'b1; tick("R9");
    chk("R9", pwm, 6'b0);
    run = 1'b1;
    repeat (20) tick("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule